// File: doc/BRIEF.md
# Output-Stationary INT8 Matrix-Multiply Core

The core computes one output tile of a matrix product: a signed 8-bit activation tile of TM rows by K columns times a signed 8-bit weight tile of K rows by TN columns. Each of the TM×TN output elements owns a private 32-bit accumulator. That accumulator keeps its partial sum until the whole reduction depth has been consumed, so only finished sums leave the block.

A tile starts with a configuration handshake that carries K. Activations and weights then arrive on two independent AXI4-Stream inputs. Each beat is SIMD lanes of 8 bits, and both streams land in local buffers deep enough for the largest K. When both tiles are complete, the core performs SIMD multiply-accumulates per output element per cycle along K. It then streams the TM×TN results row-major on an AXI4-Stream output for post-processing. A K of zero or above the buffer capacity is refused with an error flag.

Top module: `gemm_core`

## Requirements
- R1: After reset, cfg_ready_o is 1, cfg_err_o is 0, and act_tready_o, wgt_tready_o and res_tvalid_o are all 0.
- R2: A configuration is taken when cfg_valid_i and cfg_ready_o are both 1. If K is 0 or K > KMAX (512), the next cycle shows cfg_err_o=1 and cfg_ready_o=1, and no operand stream is opened. If 1 ≤ K ≤ KMAX, the tile is started and cfg_err_o is cleared.
- R3: Let S = ceil(K/SIMD). Activation row m is sent as S beats for rows m = 0..TM-1 in order. Weight column n is sent as S beats for columns n = 0..TN-1 in order. Lane j (bits 8j+7:8j) of beat s holds reduction index s*SIMD+j. The two streams are accepted independently, in any interleaving.
- R4: Result element (m,n) equals the signed 32-bit sum over k<K of A[m][k]*B[k][n].
- R5: Lanes whose reduction index is K or above in the final beat have no effect on any result.
- R6: All accumulators start from zero for each tile, so a tile's results do not depend on earlier tiles.
- R7: Results are emitted row-major, with element (m,n) at position m*TN+n. res_tlast_o is 1 only on position TM*TN-1.
- R8: With the weight stream finishing last, res_tvalid_o first goes high S+2 clock cycles after the cycle in which the last operand beat is accepted.
- R9: While res_tvalid_o=1 and res_tready_i=0, res_tvalid_o, res_tdata_o and res_tlast_o hold their values.
- R10: Exactly TM*TN results are emitted per tile. After the tlast handshake, the core is idle: cfg_ready_o=1 and res_tvalid_o=0.
- R11: Each operand tready is high only while its stream still needs beats for the current tile. Both are low while results are being emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | Configuration request |
| cfg_ready_o | output | 1 | Core idle, can take a configuration |
| cfg_k_i | input | 10 | Reduction depth K |
| cfg_err_o | output | 1 | Last configuration was refused |
| act_tvalid_i | input | 1 | Activation beat valid |
| act_tready_o | output | 1 | Activation beat accepted |
| act_tdata_i | input | 32 | SIMD signed 8-bit activations |
| wgt_tvalid_i | input | 1 | Weight beat valid |
| wgt_tready_o | output | 1 | Weight beat accepted |
| wgt_tdata_i | input | 32 | SIMD signed 8-bit weights |
| res_tvalid_o | output | 1 | Result valid |
| res_tready_i | input | 1 | Downstream ready |
| res_tdata_o | output | 32 | Accumulated result |
| res_tlast_o | output | 1 | Last element of the tile |

## Verification
The bound assertions check, on every cycle, the handshake-level behaviour:
- results hold under backpressure;
- tlast falls exactly on every TM*TN-th accepted result;
- a refused configuration raises the flag and leaves the core idle;
- operand streams are closed during output;
- the core returns to idle after the tile's last result.

The arithmetic cannot be seen by a property and is shown only by the bench's scenarios. These cover exact sums against bench-computed dot products, the masking of junk in padding lanes, accumulator clearing between tiles and the S+2 cycle latency. The bench drives random data, random K, interleaved operand streams, random backpressure, and the corner cases K=1, K=SIMD, K=KMAX with extreme operands, and out-of-range K.

// File: rtl/gemm_pkg.sv
package gemm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_COMP,
    ST_DRN1,
    ST_DRN2,
    ST_OUT
  } gemm_state_e;
endpackage

// File: rtl/gemm_ld_seq.sv
// Write sequencer for one operand stream: vector-major, step-minor.
module gemm_ld_seq #(
  parameter int NVEC      = 4,
  parameter int STEPS_MAX = 128,
  localparam int VW = (NVEC > 1) ? $clog2(NVEC) : 1,
  localparam int SW = (STEPS_MAX > 1) ? $clog2(STEPS_MAX) : 1,
  localparam int CW = $clog2(STEPS_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          active_i,
  input  logic [CW-1:0] steps_i,
  input  logic          valid_i,
  output logic          ready_o,
  output logic          wr_en_o,
  output logic [VW-1:0] wr_vec_o,
  output logic [SW-1:0] wr_step_o,
  output logic          done_o
);
  logic [VW-1:0] vec_q;
  logic [SW-1:0] step_q;
  logic          done_q;
  logic          fire, step_end, vec_end;

  assign ready_o   = active_i & ~done_q;
  assign fire      = valid_i & ready_o;
  assign step_end  = CW'(step_q) == (steps_i - CW'(1));
  assign vec_end   = vec_q == VW'(NVEC - 1);
  assign wr_en_o   = fire;
  assign wr_vec_o  = vec_q;
  assign wr_step_o = step_q;
  assign done_o    = done_q | (fire & step_end & vec_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q  <= '0;
      step_q <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      vec_q  <= '0;
      step_q <= '0;
      done_q <= 1'b0;
    end else if (fire) begin
      if (step_end) begin
        step_q <= '0;
        if (vec_end) done_q <= 1'b1;
        else         vec_q  <= vec_q + 1'b1;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gemm_opbuf.sv
// Full-depth operand store: one bank per row/column, all banks read in parallel.
module gemm_opbuf #(
  parameter int NVEC      = 4,
  parameter int SIMD      = 4,
  parameter int STEPS_MAX = 128,
  localparam int VW = (NVEC > 1) ? $clog2(NVEC) : 1,
  localparam int SW = (STEPS_MAX > 1) ? $clog2(STEPS_MAX) : 1,
  localparam int BW = SIMD * 8
) (
  input  logic               clk_i,
  input  logic               wr_en_i,
  input  logic [VW-1:0]      wr_vec_i,
  input  logic [SW-1:0]      wr_step_i,
  input  logic [BW-1:0]      wr_data_i,
  input  logic               rd_en_i,
  input  logic [SW-1:0]      rd_step_i,
  output logic [NVEC*BW-1:0] rd_data_o
);
  for (genvar v = 0; v < NVEC; v++) begin : g_bank
    logic [BW-1:0] mem [STEPS_MAX];
    logic [BW-1:0] rd_q;
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_vec_i == VW'(v))) mem[wr_step_i] <= wr_data_i;
      if (rd_en_i) rd_q <= mem[rd_step_i];
    end
    assign rd_data_o[v*BW +: BW] = rd_q;
  end
endmodule

// File: rtl/gemm_mac_array.sv
// TM x TN output-stationary accumulators, SIMD lanes per step.
module gemm_mac_array #(
  parameter int TM    = 4,
  parameter int TN    = 4,
  parameter int SIMD  = 4,
  parameter int ACC_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   en_i,
  input  logic [SIMD-1:0]        lane_mask_i,
  input  logic [TM*SIMD*8-1:0]   act_i,
  input  logic [TN*SIMD*8-1:0]   wgt_i,
  output logic [TM*TN*ACC_W-1:0] acc_o
);
  for (genvar m = 0; m < TM; m++) begin : g_row
    for (genvar n = 0; n < TN; n++) begin : g_col
      logic signed [ACC_W-1:0] acc_q;
      logic signed [ACC_W-1:0] dot;
      always_comb begin
        dot = '0;
        for (int l = 0; l < SIMD; l++) begin
          logic signed [15:0] prod;
          prod = 16'($signed(act_i[(m*SIMD+l)*8 +: 8])) *
                 16'($signed(wgt_i[(n*SIMD+l)*8 +: 8]));
          if (lane_mask_i[l]) dot = dot + ACC_W'(prod);
        end
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   acc_q <= '0;
        else if (clr_i) acc_q <= '0;
        else if (en_i)  acc_q <= acc_q + dot;
      end
      assign acc_o[(m*TN+n)*ACC_W +: ACC_W] = acc_q;
    end
  end
endmodule

// File: rtl/gemm_ctrl.sv
module gemm_ctrl
  import gemm_pkg::*;
#(
  parameter int TM   = 4,
  parameter int TN   = 4,
  parameter int SIMD = 4,
  parameter int KMAX = 512,
  localparam int STEPS_MAX = (KMAX + SIMD - 1) / SIMD,
  localparam int KW = $clog2(KMAX + 1),
  localparam int SW = (STEPS_MAX > 1) ? $clog2(STEPS_MAX) : 1,
  localparam int CW = $clog2(STEPS_MAX + 1),
  localparam int NOUT = TM * TN,
  localparam int IW = (NOUT > 1) ? $clog2(NOUT) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_valid_i,
  input  logic [KW-1:0]   cfg_k_i,
  output logic            cfg_ready_o,
  output logic            cfg_err_o,
  input  logic            act_done_i,
  input  logic            wgt_done_i,
  output logic            start_o,
  output logic            loading_o,
  output logic [CW-1:0]   steps_o,
  output logic            rd_en_o,
  output logic [SW-1:0]   rd_step_o,
  output logic            mac_en_o,
  output logic [SIMD-1:0] mac_mask_o,
  output logic            out_valid_o,
  output logic [IW-1:0]   out_idx_o,
  output logic            out_last_o,
  input  logic            out_ready_i
);
  gemm_state_e     state_q;
  logic [KW-1:0]   k_q;
  logic [CW-1:0]   steps_q;
  logic [SW-1:0]   step_q;
  logic            err_q, mac_en_q;
  logic [SIMD-1:0] mac_mask_q;
  logic [IW-1:0]   out_idx_q;
  logic            k_ok, last_step;
  logic [CW-1:0]   steps_d;

  assign k_ok      = (cfg_k_i != '0) && (cfg_k_i <= KW'(KMAX));
  assign steps_d   = CW'((int'(cfg_k_i) + SIMD - 1) / SIMD);
  assign last_step = CW'(step_q) == (steps_q - CW'(1));

  assign cfg_ready_o = state_q == ST_IDLE;
  assign cfg_err_o   = err_q;
  assign start_o     = cfg_ready_o & cfg_valid_i & k_ok;
  assign loading_o   = state_q == ST_LOAD;
  assign steps_o     = steps_q;
  assign rd_en_o     = state_q == ST_COMP;
  assign rd_step_o   = step_q;
  assign mac_en_o    = mac_en_q;
  assign mac_mask_o  = mac_mask_q;
  assign out_valid_o = state_q == ST_OUT;
  assign out_idx_o   = out_idx_q;
  assign out_last_o  = out_idx_q == IW'(NOUT - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      k_q        <= '0;
      steps_q    <= '0;
      step_q     <= '0;
      err_q      <= 1'b0;
      mac_en_q   <= 1'b0;
      mac_mask_q <= '0;
      out_idx_q  <= '0;
    end else begin
      mac_en_q <= rd_en_o;
      // lanes past K in the final step contribute nothing
      for (int l = 0; l < SIMD; l++)
        mac_mask_q[l] <= (int'(step_q) * SIMD + l) < int'(k_q);
      case (state_q)
        ST_IDLE: if (cfg_valid_i) begin
          err_q <= ~k_ok;
          if (k_ok) begin
            k_q       <= cfg_k_i;
            steps_q   <= steps_d;
            step_q    <= '0;
            out_idx_q <= '0;
            state_q   <= ST_LOAD;
          end
        end
        ST_LOAD: if (act_done_i && wgt_done_i) state_q <= ST_COMP;
        ST_COMP: begin
          if (last_step) state_q <= ST_DRN1;
          else           step_q  <= step_q + 1'b1;
        end
        ST_DRN1: state_q <= ST_DRN2;
        ST_DRN2: state_q <= ST_OUT;
        ST_OUT: if (out_ready_i) begin
          if (out_last_o) state_q   <= ST_IDLE;
          else            out_idx_q <= out_idx_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gemm_core.sv
module gemm_core #(
  parameter int TM    = 4,
  parameter int TN    = 4,
  parameter int SIMD  = 4,
  parameter int KMAX  = 512,
  parameter int ACC_W = 32,
  localparam int KW = $clog2(KMAX + 1),
  localparam int BW = SIMD * 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_valid_i,
  output logic             cfg_ready_o,
  input  logic [KW-1:0]    cfg_k_i,
  output logic             cfg_err_o,
  input  logic             act_tvalid_i,
  output logic             act_tready_o,
  input  logic [BW-1:0]    act_tdata_i,
  input  logic             wgt_tvalid_i,
  output logic             wgt_tready_o,
  input  logic [BW-1:0]    wgt_tdata_i,
  output logic             res_tvalid_o,
  input  logic             res_tready_i,
  output logic [ACC_W-1:0] res_tdata_o,
  output logic             res_tlast_o
);
  localparam int STEPS_MAX = (KMAX + SIMD - 1) / SIMD;
  localparam int SW   = (STEPS_MAX > 1) ? $clog2(STEPS_MAX) : 1;
  localparam int CW   = $clog2(STEPS_MAX + 1);
  localparam int NOUT = TM * TN;
  localparam int IW   = (NOUT > 1) ? $clog2(NOUT) : 1;
  localparam int AVW  = (TM > 1) ? $clog2(TM) : 1;
  localparam int WVW  = (TN > 1) ? $clog2(TN) : 1;

  logic            start, loading, act_done, wgt_done;
  logic [CW-1:0]   steps;
  logic            rd_en, mac_en;
  logic [SW-1:0]   rd_step;
  logic [SIMD-1:0] mac_mask;
  logic [IW-1:0]   out_idx;
  logic            act_wr, wgt_wr;
  logic [AVW-1:0]  act_vec;
  logic [WVW-1:0]  wgt_vec;
  logic [SW-1:0]   act_step, wgt_step;
  logic [TM*BW-1:0] act_rd;
  logic [TN*BW-1:0] wgt_rd;
  logic [NOUT*ACC_W-1:0] acc;

  gemm_ctrl #(.TM(TM), .TN(TN), .SIMD(SIMD), .KMAX(KMAX)) u_ctrl (
    .clk_i, .rst_ni, .cfg_valid_i, .cfg_k_i, .cfg_ready_o, .cfg_err_o,
    .act_done_i(act_done), .wgt_done_i(wgt_done), .start_o(start),
    .loading_o(loading), .steps_o(steps), .rd_en_o(rd_en), .rd_step_o(rd_step),
    .mac_en_o(mac_en), .mac_mask_o(mac_mask), .out_valid_o(res_tvalid_o),
    .out_idx_o(out_idx), .out_last_o(res_tlast_o), .out_ready_i(res_tready_i)
  );

  gemm_ld_seq #(.NVEC(TM), .STEPS_MAX(STEPS_MAX)) u_act_seq (
    .clk_i, .rst_ni, .start_i(start), .active_i(loading), .steps_i(steps),
    .valid_i(act_tvalid_i), .ready_o(act_tready_o), .wr_en_o(act_wr),
    .wr_vec_o(act_vec), .wr_step_o(act_step), .done_o(act_done)
  );

  gemm_ld_seq #(.NVEC(TN), .STEPS_MAX(STEPS_MAX)) u_wgt_seq (
    .clk_i, .rst_ni, .start_i(start), .active_i(loading), .steps_i(steps),
    .valid_i(wgt_tvalid_i), .ready_o(wgt_tready_o), .wr_en_o(wgt_wr),
    .wr_vec_o(wgt_vec), .wr_step_o(wgt_step), .done_o(wgt_done)
  );

  gemm_opbuf #(.NVEC(TM), .SIMD(SIMD), .STEPS_MAX(STEPS_MAX)) u_act_buf (
    .clk_i, .wr_en_i(act_wr), .wr_vec_i(act_vec), .wr_step_i(act_step),
    .wr_data_i(act_tdata_i), .rd_en_i(rd_en), .rd_step_i(rd_step), .rd_data_o(act_rd)
  );

  gemm_opbuf #(.NVEC(TN), .SIMD(SIMD), .STEPS_MAX(STEPS_MAX)) u_wgt_buf (
    .clk_i, .wr_en_i(wgt_wr), .wr_vec_i(wgt_vec), .wr_step_i(wgt_step),
    .wr_data_i(wgt_tdata_i), .rd_en_i(rd_en), .rd_step_i(rd_step), .rd_data_o(wgt_rd)
  );

  gemm_mac_array #(.TM(TM), .TN(TN), .SIMD(SIMD), .ACC_W(ACC_W)) u_mac (
    .clk_i, .rst_ni, .clr_i(start), .en_i(mac_en), .lane_mask_i(mac_mask),
    .act_i(act_rd), .wgt_i(wgt_rd), .acc_o(acc)
  );

  assign res_tdata_o = acc[out_idx*ACC_W +: ACC_W];
endmodule

// File: rtl/gemm_core_chk.sv
module gemm_core_chk #(
  parameter int TM    = 4,
  parameter int TN    = 4,
  parameter int KMAX  = 512,
  parameter int KW    = 10,
  parameter int ACC_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_valid_i,
  input logic             cfg_ready_o,
  input logic [KW-1:0]    cfg_k_i,
  input logic             cfg_err_o,
  input logic             act_tready_o,
  input logic             wgt_tready_o,
  input logic             res_tvalid_o,
  input logic             res_tready_i,
  input logic [ACC_W-1:0] res_tdata_o,
  input logic             res_tlast_o
);
  localparam int NOUT = TM * TN;
  int beat_q;
  logic k_bad;

  assign k_bad = (cfg_k_i == '0) || (int'(cfg_k_i) > KMAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) beat_q <= 0;
    else if (res_tvalid_o && res_tready_i) beat_q <= (beat_q == NOUT - 1) ? 0 : beat_q + 1;
  end

  a_r2_reject_bad_k: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && cfg_ready_o && k_bad |=> cfg_err_o && cfg_ready_o && !act_tready_o);

  a_r2_accept_good_k: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && cfg_ready_o && !k_bad |=> !cfg_err_o && !cfg_ready_o);

  a_r7_tlast_position: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_tvalid_o |-> (res_tlast_o == (beat_q == NOUT - 1)));

  a_r9_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_tvalid_o && !res_tready_i |=> res_tvalid_o && $stable(res_tdata_o) && $stable(res_tlast_o));

  a_r10_idle_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_tvalid_o && res_tready_i && res_tlast_o |=> cfg_ready_o && !res_tvalid_o);

  a_r10_no_result_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ready_o |-> !res_tvalid_o);

  a_r11_streams_closed_on_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_tvalid_o |-> !act_tready_o && !wgt_tready_o);
endmodule

bind gemm_core gemm_core_chk #(.TM(TM), .TN(TN), .KMAX(KMAX), .KW(KW), .ACC_W(ACC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_valid_i(cfg_valid_i), .cfg_ready_o(cfg_ready_o),
  .cfg_k_i(cfg_k_i), .cfg_err_o(cfg_err_o), .act_tready_o(act_tready_o),
  .wgt_tready_o(wgt_tready_o), .res_tvalid_o(res_tvalid_o), .res_tready_i(res_tready_i),
  .res_tdata_o(res_tdata_o), .res_tlast_o(res_tlast_o)
);

// File: tb/gemm_core_bench.sv
module gemm_core_bench;
  localparam int TM = 4, TN = 4, SIMD = 4, KMAX = 512;
  localparam int KW = $clog2(KMAX + 1);
  localparam int BW = SIMD * 8;
  localparam int NOUT = TM * TN;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_valid = 1'b0, cfg_ready, cfg_err;
  logic [KW-1:0] cfg_k = '0;
  logic act_tvalid = 1'b0, act_tready, wgt_tvalid = 1'b0, wgt_tready;
  logic [BW-1:0] act_tdata = '0, wgt_tdata = '0;
  logic res_tvalid, res_tready = 1'b0, res_tlast;
  logic [31:0] res_tdata;

  int total = 0, bad = 0;
  logic signed [7:0] a_m [TM][KMAX];
  logic signed [7:0] b_m [TN][KMAX];

  always #(CLK_PERIOD/2) clk = ~clk;

  gemm_core #(.TM(TM), .TN(TN), .SIMD(SIMD), .KMAX(KMAX)) u_gemm_core (
    .clk_i(clk), .rst_ni(rst_n), .cfg_valid_i(cfg_valid), .cfg_ready_o(cfg_ready),
    .cfg_k_i(cfg_k), .cfg_err_o(cfg_err), .act_tvalid_i(act_tvalid), .act_tready_o(act_tready),
    .act_tdata_i(act_tdata), .wgt_tvalid_i(wgt_tvalid), .wgt_tready_o(wgt_tready),
    .wgt_tdata_i(wgt_tdata), .res_tvalid_o(res_tvalid), .res_tready_i(res_tready),
    .res_tdata_o(res_tdata), .res_tlast_o(res_tlast)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_val(int m, int n, int k);
    int s = 0;
    for (int i = 0; i < k; i++) s += int'(a_m[m][i]) * int'(b_m[n][i]);
    return s;
  endfunction

  // padding lanes carry junk on purpose (R5)
  function automatic logic [BW-1:0] beat(bit is_act, int v, int s, int k);
    logic [BW-1:0] d;
    for (int l = 0; l < SIMD; l++) begin
      int idx = s * SIMD + l;
      if (idx < k) d[l*8 +: 8] = is_act ? a_m[v][idx] : b_m[v][idx];
      else         d[l*8 +: 8] = 8'($urandom);
    end
    return d;
  endfunction

  task automatic push_act(input logic [BW-1:0] d, input bit gaps);
    if (gaps && ($urandom % 4 == 0)) begin act_tvalid = 1'b0; @(negedge clk); end
    act_tdata = d; act_tvalid = 1'b1;
    while (!act_tready) @(negedge clk);
    @(negedge clk);
    act_tvalid = 1'b0;
  endtask

  task automatic push_wgt(input logic [BW-1:0] d, input bit gaps);
    if (gaps && ($urandom % 4 == 0)) begin wgt_tvalid = 1'b0; @(negedge clk); end
    wgt_tdata = d; wgt_tvalid = 1'b1;
    while (!wgt_tready) @(negedge clk);
    @(negedge clk);
    wgt_tvalid = 1'b0;
  endtask

  task automatic send_acts(int k, bit gaps);
    int st = (k + SIMD - 1) / SIMD;
    for (int m = 0; m < TM; m++)
      for (int s = 0; s < st; s++) push_act(beat(1'b1, m, s, k), gaps);
  endtask

  task automatic send_wgts(int k, bit gaps);
    int st = (k + SIMD - 1) / SIMD;
    for (int n = 0; n < TN; n++)
      for (int s = 0; s < st; s++) push_wgt(beat(1'b0, n, s, k), gaps);
  endtask

  // fill: 0 random, 1 both -128, 2 act -128 / wgt 127
  task automatic run_tile(int k, int fill, bit concurrent, bit bp);
    int st = (k + SIMD - 1) / SIMD;
    int idx = 0, guard = 0, c = 0;
    bit have_prev = 0;
    logic [31:0] prev_d;
    logic prev_l;
    for (int i = 0; i < KMAX; i++) begin
      for (int m = 0; m < TM; m++) a_m[m][i] = (fill == 0) ? 8'($urandom) : -8'sd128;
      for (int n = 0; n < TN; n++)
        b_m[n][i] = (fill == 0) ? 8'($urandom) : (fill == 1 ? -8'sd128 : 8'sd127);
    end
    cfg_k = KW'(k); cfg_valid = 1'b1;
    chk(cfg_ready == 1'b1, "R2 cfg_ready before start", cfg_ready, 1);
    @(negedge clk);
    cfg_valid = 1'b0;
    chk(!cfg_err && act_tready && wgt_tready, "R2/R11 tile started", {cfg_err, act_tready, wgt_tready}, 3);
    if (concurrent) begin
      fork
        send_acts(k, 1'b1);
        send_wgts(k, 1'b1);
      join
      while (!res_tvalid && guard < 2000) begin @(negedge clk); guard++; end
    end else begin
      send_acts(k, 1'b1);
      chk(!act_tready && wgt_tready, "R11 act closed after full tile", act_tready, 0);
      send_wgts(k, 1'b0);
      while (!res_tvalid && c < 2000) begin @(negedge clk); c++; end
      chk(c == st + 2, "R8 latency", c, st + 2);
    end
    guard = 0;
    while (idx < NOUT && guard < 5000) begin
      res_tready = bp ? 1'($urandom % 2) : 1'b1;
      if (res_tvalid) begin
        if (have_prev)
          chk(res_tdata == prev_d && res_tlast == prev_l, "R9 hold under stall", res_tdata, prev_d);
        chk(!act_tready && !wgt_tready, "R11 streams closed", {act_tready, wgt_tready}, 0);
        chk($signed(res_tdata) == exp_val(idx / TN, idx % TN, k), "R4/R5/R6 result",
            $signed(res_tdata), exp_val(idx / TN, idx % TN, k));
        chk(res_tlast == (idx == NOUT - 1), "R7 tlast position", res_tlast, idx == NOUT - 1);
        if (res_tready) begin idx++; have_prev = 0; end
        else begin have_prev = 1; prev_d = res_tdata; prev_l = res_tlast; end
      end
      @(negedge clk);
      guard++;
    end
    res_tready = 1'b0;
    chk(cfg_ready && !res_tvalid, "R10 idle after tile", {cfg_ready, res_tvalid}, 2);
    chk(idx == NOUT, "R10 result count", idx, NOUT);
  endtask

  task automatic bad_cfg(int k);
    cfg_k = KW'(k); cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
    chk(cfg_err && cfg_ready, "R2 bad K refused", {cfg_err, cfg_ready}, 3);
    @(negedge clk);
    chk(!act_tready && !wgt_tready && !res_tvalid, "R2 bad K not started",
        {act_tready, wgt_tready, res_tvalid}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(cfg_ready && !cfg_err && !act_tready && !wgt_tready && !res_tvalid, "R1 reset state",
        {cfg_ready, cfg_err, act_tready, wgt_tready, res_tvalid}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_ready && !res_tvalid, "R1 after reset release", {cfg_ready, res_tvalid}, 2);
    run_tile(1, 0, 1'b0, 1'b0);            // R3 R8 single element depth
    run_tile(SIMD, 0, 1'b0, 1'b1);         // exact multiple
    run_tile(7, 0, 1'b0, 1'b1);            // R5 padded final step
    bad_cfg(0);                            // R2
    bad_cfg(KMAX + 1);                     // R2
    run_tile(5, 0, 1'b1, 1'b1);            // R3 interleaved, R6 after refusal
    run_tile(KMAX, 1, 1'b0, 1'b0);         // R4 extreme positive sum
    run_tile(KMAX - 1, 2, 1'b0, 1'b1);     // R4 extreme negative sum
    for (int t = 0; t < 6; t++)
      run_tile(1 + int'($urandom % 80), 0, 1'($urandom % 2), 1'($urandom % 2));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule